// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Cross-Conduction Guard

This block sits at the input of one inverter phase. It takes two switch commands, one for the upper transistor (active low) and one for the lower transistor (active high), and turns them into two registered gate enables that can never be on together. When a side asks to turn on, its enable rises only after that request has been the only one present, with no blocking condition, for a programmed number of clock cycles. This gives a dead time in which both switches are off between one switch turning off and the other turning on. A fixed floor sits under the programmed value, so a small or zero setting still leaves a minimum gap.

A shutdown input and a fault input each force both enables off. An undervoltage flag on the upper side's floating supply forces the upper enable off and latches it there, while the lower side keeps switching. The latch releases only when the supply is good again and the upper command shows a fresh assertion edge, so a command that was held on through the supply dip does not turn the switch back on by itself. One instance is placed per phase, and `dt_prog` is normally tied to a configuration value.

Top module: `phase_gate_guard`

## Requirements
- R1: `hs_cmd_n` = 0 requests the upper switch and `ls_cmd` = 1 requests the lower switch. Both enables are active high, and both are 0 while `rst` is high and in the first cycle after it.
- R2: When both commands request at the same clock edge, both enables are 0 after that edge. `hs_en` and `ls_en` are never 1 in the same cycle.
- R3: Let N = max(`dt_prog`, DT_MIN). A side's enable rises at the clock edge that samples that side's request for the (N+1)-th consecutive time, where each of those samples has no opposite request, no shutdown or fault, and, for the upper side, no undervoltage lockout. The enable then stays high for as long as these conditions hold.
- R4: When `dt_prog` is below DT_MIN (default 25 cycles), the wait is DT_MIN cycles. Any enable rise therefore comes at least DT_MIN cycles after both enables were last seen off following a high enable.
- R5: If a request is withdrawn or blocked before its wait has elapsed, the count restarts from zero when the request returns.
- R6: An enable falls at the first clock edge that samples its command inactive.
- R7: `shutdown` = 1 or `fault` = 1 forces both enables to 0 at the next edge. After release, the full wait of R3 applies again.
- R8: `hs_uv` = 1 forces `hs_en` to 0 at the next edge. `ls_en` behaves as if `hs_uv` were 0.
- R9: After `hs_uv` returns to 0, `hs_en` stays 0 until an edge samples `hs_cmd_n` going from 1 to 0 with `hs_uv` = 0. The R3 count starts at the edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_cmd_n | input | 1 | Upper switch command, 0 = on |
| ls_cmd | input | 1 | Lower switch command, 1 = on |
| dt_prog | input | DT_W | Programmed dead time in clock cycles |
| shutdown | input | 1 | Forces both enables off while high |
| fault | input | 1 | Forces both enables off while high |
| hs_uv | input | 1 | Upper floating supply undervoltage flag |
| hs_en | output | 1 | Upper gate enable |
| ls_en | output | 1 | Lower gate enable |

## Verification
The bench compares both enables against expected values in every cycle. This exposes an off-by-one in the dead-time counter, which would move the rising edge one cycle early or late. It also exposes a floor that was not applied, which would let a setting of 10 turn the switch on after 10 cycles instead of 25. Requests that are withdrawn part way through the wait check that the count restarts, so a timer that only paused would turn on too early. Overlapping requests, shutdown and fault pulses, and an undervoltage episode with the upper command held on throughout target the remaining corners. A guard without a rearm latch would turn the upper switch back on as soon as the supply recovered. A guard with a shared lockout would wrongly stop the lower switch during the dip.

// File: rtl/dt_gate_pkg.sv
package dt_gate_pkg;

    // Index of each switch within the per-side arrays
    typedef enum logic {
        SIDE_HI = 1'b0,
        SIDE_LO = 1'b1
    } side_e;

    // One flag per switch of the half bridge
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    localparam int unsigned NUM_SIDES = 2;

    // Effective wait: programmed value, never below the fixed floor
    function automatic int unsigned floor_dead(input int unsigned prog,
                                               input int unsigned floor_cyc);
        return (prog < floor_cyc) ? floor_cyc : prog;
    endfunction

    // True when exactly one side asks to conduct
    function automatic logic sole_request(input pair_t r);
        return r.hi ^ r.lo;
    endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import dt_gate_pkg::*;
(
    input  logic  hs_cmd_n,
    input  logic  ls_cmd,
    input  logic  shutdown,
    input  logic  fault,
    input  logic  hs_ok,
    output logic  hi_req,
    output pair_t want
);
    pair_t req;
    logic  blocked;

    always_comb begin
        req.hi  = ~hs_cmd_n;
        req.lo  = ls_cmd;
        // A conflicting pair of requests, or an external stop, blocks both sides
        blocked = shutdown | fault | ~sole_request(req);
        want.hi = req.hi & ~blocked & hs_ok;
        want.lo = req.lo & ~blocked;
        hi_req  = req.hi;
    end
endmodule

// File: rtl/uv_rearm.sv
module uv_rearm (
    input  logic clk,
    input  logic rst,
    input  logic hs_uv,
    input  logic hi_req,
    output logic hs_ok
);
    logic lockout;
    logic req_prev;
    logic req_rise;

    assign req_rise = hi_req & ~req_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lockout  <= 1'b0;
            req_prev <= 1'b0;
        end else begin
            req_prev <= hi_req;
            if (hs_uv) begin
                lockout <= 1'b1;
            end else if (lockout && req_rise) begin
                lockout <= 1'b0;
            end
        end
    end

    assign hs_ok = ~lockout & ~hs_uv;
endmodule

// File: rtl/dt_timer.sv
module dt_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             want,
    input  logic [CNT_W-1:0] span,
    output logic             en
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            en  <= 1'b0;
        end else begin
            if (!want) begin
                cnt <= '0;
            end else if (cnt < span) begin
                cnt <= cnt + 1'b1;
            end
            en <= want && (cnt >= span);
        end
    end
endmodule

// File: rtl/phase_gate_guard.sv
module phase_gate_guard
    import dt_gate_pkg::*;
#(
    parameter int DT_W   = 8,
    parameter int DT_MIN = 25
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hs_cmd_n,
    input  logic            ls_cmd,
    input  logic [DT_W-1:0] dt_prog,
    input  logic            shutdown,
    input  logic            fault,
    input  logic            hs_uv,
    output logic            hs_en,
    output logic            ls_en
);
    localparam int CNT_W = DT_W;

    logic                 hs_ok;
    logic                 hi_req;
    pair_t                want;
    logic [CNT_W-1:0]     span;
    logic [NUM_SIDES-1:0] want_vec;
    logic [NUM_SIDES-1:0] en_vec;

    assign span = CNT_W'(floor_dead(32'(dt_prog), DT_MIN));

    cmd_decode u_dec (
        .hs_cmd_n (hs_cmd_n),
        .ls_cmd   (ls_cmd),
        .shutdown (shutdown),
        .fault    (fault),
        .hs_ok    (hs_ok),
        .hi_req   (hi_req),
        .want     (want)
    );

    uv_rearm u_rearm (
        .clk    (clk),
        .rst    (rst),
        .hs_uv  (hs_uv),
        .hi_req (hi_req),
        .hs_ok  (hs_ok)
    );

    assign want_vec[SIDE_HI] = want.hi;
    assign want_vec[SIDE_LO] = want.lo;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dt_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .want (want_vec[s]),
            .span (span),
            .en   (en_vec[s])
        );
    end

    assign hs_en = en_vec[SIDE_HI];
    assign ls_en = en_vec[SIDE_LO];
endmodule

// File: rtl/phase_gate_guard_chk.sv
module phase_gate_guard_chk #(
    parameter int DT_W   = 8,
    parameter int DT_MIN = 25
) (
    input logic            clk,
    input logic            rst,
    input logic            hs_cmd_n,
    input logic            ls_cmd,
    input logic [DT_W-1:0] dt_prog,
    input logic            shutdown,
    input logic            fault,
    input logic            hs_uv,
    input logic            hs_en,
    input logic            ls_en
);
    localparam int GAP_W = DT_W + 1;

    // Cycles since either enable was last seen high
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
        end else if (hs_en || ls_en) begin
            gap <= '0;
        end else if (gap != {GAP_W{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    p_conflict_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!hs_cmd_n && ls_cmd) |=> (!hs_en && !ls_en));

    p_dead_floor_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_en) || $rose(ls_en)) |-> (gap >= GAP_W'(DT_MIN)));

    p_release_hi_r6: assert property (@(posedge clk) disable iff (rst)
        hs_cmd_n |=> !hs_en);

    p_release_lo_r6: assert property (@(posedge clk) disable iff (rst)
        !ls_cmd |=> !ls_en);

    p_stop_off_r7: assert property (@(posedge clk) disable iff (rst)
        (shutdown || fault) |=> (!hs_en && !ls_en));

    p_uv_hi_off_r8: assert property (@(posedge clk) disable iff (rst)
        hs_uv |=> !hs_en);

    // R3: a fresh enable needs its request present in the previous cycle
    p_rise_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(ls_cmd && !shutdown && !fault));

    // dt_prog only shapes the count; keep it referenced for completeness
    p_prog_known_r3: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(dt_prog));
endmodule

bind phase_gate_guard phase_gate_guard_chk #(
    .DT_W   (DT_W),
    .DT_MIN (DT_MIN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hs_cmd_n (hs_cmd_n),
    .ls_cmd   (ls_cmd),
    .dt_prog  (dt_prog),
    .shutdown (shutdown),
    .fault    (fault),
    .hs_uv    (hs_uv),
    .hs_en    (hs_en),
    .ls_en    (ls_en)
);

// File: tb/phase_gate_guard_test.sv
`timescale 1ns/1ps
module phase_gate_guard_test;
    localparam int DT_W   = 8;
    localparam int DT_MIN = 25;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hs_cmd_n = 1'b1;
    logic            ls_cmd = 1'b0;
    logic [DT_W-1:0] dt_prog = 8'd30;
    logic            shutdown = 1'b0;
    logic            fault = 1'b0;
    logic            hs_uv = 1'b0;
    logic            hs_en;
    logic            ls_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Reference state, derived from the requirement text
    int   dt_val = 30;
    int   m_run_h = 0;
    int   m_run_l = 0;
    logic m_lock = 1'b0;
    logic m_prev = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    phase_gate_guard #(.DT_W(DT_W), .DT_MIN(DT_MIN)) uut (
        .clk(clk), .rst(rst), .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd),
        .dt_prog(dt_prog), .shutdown(shutdown), .fault(fault),
        .hs_uv(hs_uv), .hs_en(hs_en), .ls_en(ls_en)
    );

    // Monitor: compares each result one ns after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({hs_en, ls_en} !== e) begin
                n_bad++;
                $display("FAIL %s: hs_en=%b ls_en=%b expected hs_en=%b ls_en=%b",
                         t, hs_en, ls_en, e[1], e[0]);
            end
        end
    end

    task automatic reset_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1;
            m_run_h = 0; m_run_l = 0; m_lock = 1'b0; m_prev = 1'b0;
            exp_q.push_back(2'b00);
            tag_q.push_back("R1 reset");
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected enables
    task automatic step(input logic hn, input logic l, input logic sd,
                        input logic fl, input logic uv, input string tag);
        int   wait_n;
        logic hreq, lreq, blk, hok, wh, wl, eh, el;
        @(negedge clk);
        rst = 1'b0;
        hs_cmd_n = hn; ls_cmd = l; shutdown = sd; fault = fl; hs_uv = uv;
        dt_prog = dt_val[DT_W-1:0];
        wait_n = (dt_val < DT_MIN) ? DT_MIN : dt_val;          // R4
        hreq = ~hn;                                            // R1
        lreq = l;
        blk  = sd | fl | (hreq & lreq);                        // R2, R7
        hok  = ~m_lock & ~uv;                                  // R8, R9
        wh   = hreq & ~blk & hok;
        wl   = lreq & ~blk;
        eh   = wh && (m_run_h >= wait_n);                      // R3
        el   = wl && (m_run_l >= wait_n);
        exp_q.push_back({eh, el});
        tag_q.push_back(tag);
        m_run_h = wh ? m_run_h + 1 : 0;                        // R5
        m_run_l = wl ? m_run_l + 1 : 0;
        if (uv) m_lock = 1'b1;
        else if (m_lock && hreq && !m_prev) m_lock = 1'b0;
        m_prev = hreq;
    endtask

    task automatic hold(input int n, input logic hn, input logic l,
                        input logic sd, input logic fl, input logic uv,
                        input string tag);
        for (int i = 0; i < n; i++) step(hn, l, sd, fl, uv, tag);
    endtask

    initial begin
        reset_cycles(4);
        hold(3, 1, 0, 0, 0, 0, "R1 idle after reset");

        // Lower on, then release, then upper on: dead time and polarity
        dt_val = 30;
        hold(40, 1, 1, 0, 0, 0, "R3 lower turn-on wait");
        hold(3, 1, 0, 0, 0, 0, "R6 lower release");
        hold(45, 0, 0, 0, 0, 0, "R1 upper active-low wait");
        hold(2, 1, 0, 0, 0, 0, "R6 upper release");
        // Direct handover: upper request replaced by lower request
        hold(40, 0, 0, 0, 0, 0, "R3 upper on again");
        hold(40, 1, 1, 0, 0, 0, "R3 handover gap");
        // Conflicting requests
        hold(5, 0, 1, 0, 0, 0, "R2 both requested");
        hold(35, 1, 1, 0, 0, 0, "R2 recovery after conflict");

        // Floor under small programmed values
        dt_val = 10;
        hold(2, 1, 0, 0, 0, 0, "R4 idle");
        hold(35, 1, 1, 0, 0, 0, "R4 floor on lower");
        dt_val = 0;
        hold(35, 0, 0, 0, 0, 0, "R4 floor on upper");

        // Restart of an interrupted wait
        dt_val = 30;
        hold(2, 1, 0, 0, 0, 0, "R5 idle");
        hold(20, 0, 0, 0, 0, 0, "R5 partial wait");
        hold(2, 1, 0, 0, 0, 0, "R5 withdrawn");
        hold(40, 0, 0, 0, 0, 0, "R5 restarted wait");

        // Shutdown and fault
        hold(4, 0, 0, 1, 0, 0, "R7 shutdown");
        hold(40, 0, 0, 0, 0, 0, "R7 after shutdown");
        hold(3, 1, 1, 0, 1, 0, "R7 fault");
        hold(40, 1, 1, 0, 0, 0, "R7 after fault");

        // Upper supply undervoltage with the lower side running
        hold(6, 1, 1, 0, 0, 1, "R8 lower unaffected");
        hold(2, 1, 0, 0, 0, 0, "R8 idle");
        hold(40, 0, 0, 0, 0, 0, "R9 upper on before dip");
        hold(5, 0, 0, 0, 0, 1, "R8 upper forced off");
        hold(50, 0, 0, 0, 0, 0, "R9 held command stays off");
        hold(3, 1, 0, 0, 0, 0, "R9 command released");
        hold(40, 0, 0, 0, 0, 0, "R9 fresh edge rearms");
        hold(2, 1, 0, 0, 0, 0, "R6 final release");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule